// File: doc/BRIEF.md
# Output Round, Clamp and Encode Stage

This stage sits at the end of a filter datapath. It receives a wide signed accumulator word and turns it into a registered 16-bit sample. A 3-bit selector picks one of eight output bit positions as the least significant bit that is kept. The stage adds half of that bit's weight and then clears everything beneath it. If the rounded value no longer fits in 16 signed bits, it is clamped to the nearest full-scale code.

The clamped word can be emitted either as plain two's complement or in an inverted offset form. The inverted offset form keeps the sign bit and complements all the other bits. The word is captured on the rising clock edge. An active-low enable decides whether the captured word is presented. The disabled, high-impedance condition is modelled as a deasserted valid flag with the data lines driven to zero.

Top module: `rnd_sat_fmt`

## Requirements
- R1: `acc_i` is a signed 20-bit value whose four lowest bits lie below output bit 0, so output bit k carries the weight of `acc_i` bit k+4.
- R2: With `rnd_sel_i` = p (0 to 7), the stage adds 2^(p+3) to `acc_i` before truncating, so a remainder of exactly half an output step rounds toward positive infinity.
- R3: After rounding, output bits p-1 down to 0 are zero whenever the result is not clamped and `twos_i` is 1.
- R4: If the rounded value, in output units, is above 32767 the word becomes 0x7FFF, and if it is below -32768 the word becomes 0x8000; this includes overflow caused only by the rounding carry.
- R5: When `twos_i` is 1, the output is the rounded and clamped value in two's complement.
- R6: When `twos_i` is 0, bit 15 is passed unchanged and bits 14 to 0 are inverted. This encoding is applied after clamping, so 0x7FFF is emitted as 0x0000 and 0x8000 is emitted as 0xFFFF.
- R7: The output word is registered. It changes only after the rising `clk_i` edge that samples the inputs, giving one cycle of latency.
- R8: While `oe_ni` is 0, `valid_o` is 1 and `data_o` shows the registered word. While `oe_ni` is 1, `valid_o` is 0 and `data_o` is 0, and the registered word is kept.
- R9: Driving `rst_ni` low clears the output register to zero immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 20 | Signed internal result with 4 fractional bits |
| rnd_sel_i | input | 3 | Output bit position of the effective LSB |
| twos_i | input | 1 | 1: two's complement, 0: inverted offset binary |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 16 | Registered output word, zero while disabled |
| valid_o | output | 1 | High while the output is enabled |

## Verification
Every combination of rounding position and encoding is tried with three kinds of input. A dense run of small accumulator values near zero separates round-half-up from truncation and from round-half-even, and it shows whether low bits are cleared at the correct position. A coarse stride across the full 20-bit range, together with values at the clamp edges, separates a rounding carry that overflows from one that does not, and tells a correct clamp from a clamp of the wrong polarity. Directed steps around the clock edge, the enable and the reset separate registered behaviour from combinational behaviour.

// File: rtl/rnd_sat_fmt_pkg.sv
package rnd_sat_fmt_pkg;
  typedef enum logic {
    FMT_IOB  = 1'b0,
    FMT_TWOS = 1'b1
  } fmt_e;
endpackage

// File: rtl/rsf_round.sv
module rsf_round #(
  parameter int IN_W   = 20,
  parameter int FRAC_W = 4,
  parameter int SEL_W  = 3,
  localparam int SUM_W = IN_W + 1
) (
  input  logic [IN_W-1:0]  din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SUM_W-1:0] rnd_o
);
  logic [SUM_W-1:0] half, keep_mask, ext;

  always_comb begin
    ext       = {din_i[IN_W-1], din_i};
    half      = SUM_W'(1) << (FRAC_W + int'(sel_i) - 1);
    keep_mask = ~((SUM_W'(1) << (FRAC_W + int'(sel_i))) - SUM_W'(1));
    rnd_o     = (ext + half) & keep_mask;
  end
endmodule

// File: rtl/rsf_clamp.sv
module rsf_clamp #(
  parameter int SUM_W  = 21,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 16,
  localparam int HI_W  = SUM_W - FRAC_W
) (
  input  logic [SUM_W-1:0] rnd_i,
  output logic [OUT_W-1:0] word_o,
  output logic             sat_o
);
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

  logic [HI_W-1:0]       hi;
  logic [HI_W-OUT_W:0]   top;

  always_comb begin
    hi  = rnd_i[SUM_W-1:FRAC_W];
    top = hi[HI_W-1:OUT_W-1];
    sat_o = !((&top) || !(|top));
    if (!sat_o)           word_o = hi[OUT_W-1:0];
    else if (hi[HI_W-1])  word_o = NEG_FS;
    else                  word_o = POS_FS;
  end

  always_comb begin
    if (sat_o) p_sat_value_r4: assert (word_o == POS_FS || word_o == NEG_FS);
  end
endmodule

// File: rtl/rsf_encode.sv
module rsf_encode
  import rnd_sat_fmt_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic [OUT_W-1:0] word_i,
  input  fmt_e             fmt_i,
  output logic [OUT_W-1:0] code_o
);
  always_comb begin
    if (fmt_i == FMT_TWOS) code_o = word_i;
    else                   code_o = {word_i[OUT_W-1], ~word_i[OUT_W-2:0]};
  end

  always_comb begin
    p_msb_keep_r6: assert (code_o[OUT_W-1] == word_i[OUT_W-1]);
  end
endmodule

// File: rtl/rnd_sat_fmt.sv
module rnd_sat_fmt
  import rnd_sat_fmt_pkg::*;
#(
  parameter int IN_W   = 20,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 16,
  parameter int SEL_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  acc_i,
  input  logic [SEL_W-1:0] rnd_sel_i,
  input  logic             twos_i,
  input  logic             oe_ni,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  localparam int SUM_W = IN_W + 1;

  logic [SUM_W-1:0] rnd_w;
  logic [OUT_W-1:0] sat_word, code_w, out_q;
  logic             sat_w;

  rsf_round #(.IN_W(IN_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)) u_round (
    .din_i(acc_i), .sel_i(rnd_sel_i), .rnd_o(rnd_w)
  );

  rsf_clamp #(.SUM_W(SUM_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_clamp (
    .rnd_i(rnd_w), .word_o(sat_word), .sat_o(sat_w)
  );

  rsf_encode #(.OUT_W(OUT_W)) u_encode (
    .word_i(sat_word), .fmt_i(fmt_e'(twos_i)), .code_o(code_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= code_w;
  end

  assign valid_o = !oe_ni;
  assign data_o  = oe_ni ? '0 : out_q;

  // low bits under the chosen LSB must be clear unless clamped
  p_low_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_w |-> ((sat_word & ((OUT_W'(1) << rnd_sel_i) - OUT_W'(1))) == '0));

  p_reg_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_q == $past(code_w));

  p_reset_clear_r9: assert property (@(posedge clk_i)
    !rst_ni |-> out_q == '0);
endmodule

// File: tb/rnd_sat_fmt_tb_top.sv
module rnd_sat_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] acc = '0;
  logic [2:0]  rsel = '0;
  logic        twos = 1'b1;
  logic        oe_n = 1'b0;
  logic [15:0] dout;
  logic        vld;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rnd_sat_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .rnd_sel_i(rsel),
    .twos_i(twos), .oe_ni(oe_n), .data_o(dout), .valid_o(vld)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rounded(int x, int r);
    int s;
    s = (x + (1 << (r + 3))) >>> (r + 4);
    return s << r;
  endfunction

  function automatic logic [15:0] model(int x, int r, bit t);
    int s;
    logic [15:0] w;
    s = rounded(x, r);
    if (s > 32767)       w = 16'h7fff;
    else if (s < -32768) w = 16'h8000;
    else                 w = s[15:0];
    if (!t) w = {w[15], ~w[14:0]};
    return w;
  endfunction

  task automatic apply(int x, int r, bit t, string tag);
    int s;
    acc = x[19:0]; rsel = r[2:0]; twos = t;
    @(posedge clk); #1;
    check(tag, dout, model(x, r, t));
    s = rounded(x, r);
    if (t && s <= 32767 && s >= -32768)
      check("R3 low bits clear", dout & 16'((1 << r) - 1), 16'h0);
  endtask

  task automatic sweep_one(int x, int r, bit t);
    int s;
    s = rounded(x, r);
    if (s > 32767 || s < -32768) apply(x, r, t, "R4 clamp");
    else if (t)                  apply(x, r, t, "R2 R5 round");
    else                         apply(x, r, t, "R6 inverted offset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    check("R9 reset value", dout, 16'h0000);
    check("R8 valid while enabled", 16'(vld), 16'h0001);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    apply(16, 0, 1'b1, "R1 unit weight");
    apply(-16, 0, 1'b1, "R1 negative unit");
    apply(8, 0, 1'b1, "R2 half rounds up");
    apply(7, 0, 1'b1, "R2 below half");
    apply(-8, 0, 1'b1, "R2 negative half");
    apply(-9, 0, 1'b1, "R2 past negative half");
    apply(524280, 0, 1'b1, "R4 carry overflow");
    apply(524279, 0, 1'b1, "R4 no overflow");
    apply(-524288, 0, 1'b1, "R4 negative full scale");
    apply(524287, 0, 1'b0, "R6 clamp then invert");
    apply(-524288, 0, 1'b0, "R6 negative invert");
    apply(1000, 7, 1'b1, "R5 coarse round");

    for (int r = 0; r < 8; r++) begin
      for (int t = 0; t < 2; t++) begin
        for (int x = -600; x <= 600; x++) sweep_one(x, r, t[0]);
        for (int x = -524288; x < 524288; x += 4099) sweep_one(x, r, t[0]);
        for (int d = -20; d <= 20; d++) begin
          sweep_one(524287 - 20 + d, r, t[0]);
          sweep_one(-524288 + 20 + d, r, t[0]);
        end
      end
    end

    // R7: output holds until the sampling edge
    apply(160, 0, 1'b1, "R7 setup value");
    acc = 20'(320);
    #3 check("R7 before edge", dout, 16'h000a);
    @(posedge clk); #1;
    check("R7 after edge", dout, 16'h0014);

    // R8: disable hides data, register kept
    oe_n = 1'b1; acc = 20'(480);
    #1 check("R8 disabled data", dout, 16'h0000);
    check("R8 disabled valid", 16'(vld), 16'h0000);
    @(posedge clk); #1;
    oe_n = 1'b0;
    #1 check("R8 re-enabled data", dout, 16'h001e);
    check("R8 re-enabled valid", 16'(vld), 16'h0001);

    // R9: asynchronous clear mid-run
    #2 rst_n = 1'b0;
    #1 check("R9 async clear", dout, 16'h0000);
    @(posedge clk); #1;
    check("R9 held in reset", dout, 16'h0000);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule